// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Pinned Entries

This block is a small, fully associative cache of page translations that sits in front of a page-table walker. A request carries a virtual page number, the identifier of the requesting address space and the in-page offset. All entries are compared in parallel in the same cycle. On a hit the stored frame number is joined with the offset to form the physical address, and the permission bits are returned. On a miss the block reports it and waits for the walker to deliver the translation. The walker's fill is written into a victim slot.

Each entry can be marked global, which makes it match every address space. An entry can also be pinned at fill time, so that no later replacement or flush removes it. A flush port clears all unpinned entries, or only the unpinned, non-global entries of one address space. Two saturating counters record hits and misses so that the hit ratio can be measured.

Control is a two-state machine. LOOKUP is entered at reset and accepts requests. LOOKUP goes to REFILL when an accepted request misses. REFILL goes back to LOOKUP when a fill is accepted, whether that fill is written or dropped.

Top module: `asid_tlb`

## Requirements
- R1: A request accepted at a clock edge (`lk_valid` and `lk_ready` both high) produces `rsp_valid` high for exactly the next cycle. On a hit in that response, `rsp_hit` is 1, `rsp_paddr` = {frame, offset} with the frame in the upper bits, and `rsp_perm` is the stored permission field. When there is no hit, `rsp_hit`, `rsp_paddr` and `rsp_perm` are all zero.
- R2: A non-global entry hits only when both its page number and its address-space identifier equal the request's.
- R3: A global entry hits on a matching page number whatever the request's identifier is.
- R4: After a miss, the machine is in REFILL: `lk_ready` is 0 and `fill_ready` is 1 until a fill is accepted. While in LOOKUP, `fill_ready` is 0 and a fill on the port is ignored.
- R5: A fill goes into the lowest-numbered invalid entry when one exists. A later lookup of the same key hits.
- R6: When every entry is valid, the victim is the first unpinned entry at or after a round-robin pointer, searching upward with wraparound. The pointer starts at 0 and moves to one past the victim. Fills into invalid entries leave the pointer unchanged.
- R7: A pinned entry is never chosen as a victim and never stops being valid, except through reset.
- R8: If every entry is pinned, a fill is dropped, `overflow` is high for exactly one cycle, and the machine returns to LOOKUP.
- R9: A flush with `flush_mode`=0 invalidates every unpinned entry within one cycle.
- R10: A flush with `flush_mode`=1 invalidates, within one cycle, the entries that are unpinned, non-global and tagged with `flush_asid`. All other entries are kept.
- R11: While `flush_valid` is high, both `lk_ready` and `fill_ready` are 0. A request or fill presented in that cycle is not taken and produces no response.
- R12: `hit_count` and `miss_count` count accepted requests that hit and that miss. They hold at all-ones instead of wrapping.
- R13: After reset, all entries are invalid and unpinned, the pointer is 0, the machine is in LOOKUP, `lk_ready` is 1, and both counters, `rsp_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_off | input | OFF_W | Offset within the page |
| lk_ready | output | 1 | Lookup is accepted this cycle |
| rsp_valid | output | 1 | Response to the request accepted at the last edge |
| rsp_hit | output | 1 | Response is a hit |
| rsp_paddr | output | PFN_W+OFF_W | Physical address {frame, offset} on a hit, else 0 |
| rsp_perm | output | PERM_W | Permission bits on a hit, else 0 |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_asid | input | ASID_W | Identifier of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | PERM_W | Permission bits of the fill |
| fill_global | input | 1 | Fill matches any identifier |
| fill_wired | input | 1 | Fill is pinned against replacement and flush |
| fill_ready | output | 1 | Fill is accepted this cycle |
| flush_valid | input | 1 | Flush command |
| flush_mode | input | 1 | 0: all unpinned entries, 1: one identifier |
| flush_asid | input | ASID_W | Identifier to flush when `flush_mode` is 1 |
| overflow | output | 1 | One-cycle pulse when a fill was dropped because all entries are pinned |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The checker assumes that no two valid entries can match the same request. This holds because the walker only fills a key after that exact key has missed. The bench's stimulus follows the same rule: it fills only the key that has just missed, and it never installs a non-global entry whose page number is already covered by a global one. The checker also assumes that `flush_valid` is held for one cycle at a time, and that inputs change only away from the clock edge. The bench drives every input one time unit after the rising edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } tlb_state_e;

    typedef enum logic {
        FLUSH_ALL  = 1'b0,
        FLUSH_ASID = 1'b1
    } flush_mode_e;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic fill_valid,
    input  logic flush_valid,
    input  logic lk_hit,
    output logic lk_ready,
    output logic fill_ready,
    output logic lk_fire,
    output logic fill_fire
);

    tlb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (lk_fire && !lk_hit) state_d = ST_REFILL;
            ST_REFILL: if (fill_fire)          state_d = ST_LOOKUP;
            default:                           state_d = ST_LOOKUP;
        endcase
    end

    // outputs
    always_comb begin
        lk_ready   = 1'b0;
        fill_ready = 1'b0;
        unique case (state_q)
            ST_LOOKUP: lk_ready   = !flush_valid;
            ST_REFILL: fill_ready = !flush_valid;
            default: begin
                lk_ready   = 1'b0;
                fill_ready = 1'b0;
            end
        endcase
        lk_fire   = lk_valid && lk_ready;
        fill_fire = fill_valid && fill_ready;
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0]             glob,
    input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
    input  logic [N-1:0][ASID_W-1:0] asid_tab,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [ASID_W-1:0]        req_asid,
    output logic [N-1:0]             hit_vec,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g]
                         && (vpn_tab[g] == req_vpn)
                         && (glob[g] || (asid_tab[g] == req_asid));
    end

    assign hit = |hit_vec;

    // lowest matching index
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     wired,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_ok,
    output logic             use_rr
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             rr_found;
    logic [IDX_W-1:0] rr_idx;

    // lowest invalid slot
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // first unpinned slot at or after the pointer, wrapping
    always_comb begin
        int j;
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            j = (int'(rr_ptr) + k) % N;
            if (!wired[j]) begin
                rr_found = 1'b1;
                rr_idx   = IDX_W'(j);
            end
        end
    end

    assign victim_ok  = free_found || rr_found;
    assign use_rr     = !free_found && rr_found;
    assign victim_idx = free_found ? free_idx : rr_idx;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int OFF_W   = 12,
    parameter int PERM_W  = 3,
    parameter int CNT_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic [OFF_W-1:0]       lk_off,
    output logic                   lk_ready,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic [PERM_W-1:0]      rsp_perm,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [ASID_W-1:0]      fill_asid,
    input  logic [PFN_W-1:0]       fill_pfn,
    input  logic [PERM_W-1:0]      fill_perm,
    input  logic                   fill_global,
    input  logic                   fill_wired,
    output logic                   fill_ready,
    input  logic                   flush_valid,
    input  logic                   flush_mode,
    input  logic [ASID_W-1:0]      flush_asid,
    output logic                   overflow,
    output logic [CNT_W-1:0]       hit_count,
    output logic [CNT_W-1:0]       miss_count
);

    localparam int N     = ENTRIES;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int PA_W  = PFN_W + OFF_W;

    // entry storage
    logic [N-1:0]             e_valid;
    logic [N-1:0]             e_wired;
    logic [N-1:0]             e_global;
    logic [N-1:0][VPN_W-1:0]  e_vpn;
    logic [N-1:0][ASID_W-1:0] e_asid;
    logic [N-1:0][PFN_W-1:0]  e_pfn;
    logic [N-1:0][PERM_W-1:0] e_perm;
    logic [IDX_W-1:0]         rr_ptr;

    logic [N-1:0]     hit_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             victim_ok;
    logic             use_rr;
    logic             lk_fire;
    logic             fill_fire;
    logic             flush_by_asid;

    logic             rsp_valid_q;
    logic             rsp_hit_q;
    logic [PA_W-1:0]  rsp_paddr_q;
    logic [PERM_W-1:0] rsp_perm_q;
    logic             overflow_q;

    assign flush_by_asid = (flush_mode_e'(flush_mode) == FLUSH_ASID);

    tlb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .fill_valid (fill_valid),
        .flush_valid(flush_valid),
        .lk_hit     (hit),
        .lk_ready   (lk_ready),
        .fill_ready (fill_ready),
        .lk_fire    (lk_fire),
        .fill_fire  (fill_fire)
    );

    tlb_match #(
        .N     (N),
        .VPN_W (VPN_W),
        .ASID_W(ASID_W),
        .IDX_W (IDX_W)
    ) u_match (
        .valid   (e_valid),
        .glob    (e_global),
        .vpn_tab (e_vpn),
        .asid_tab(e_asid),
        .req_vpn (lk_vpn),
        .req_asid(lk_asid),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    tlb_victim #(
        .N    (N),
        .IDX_W(IDX_W)
    ) u_victim (
        .valid     (e_valid),
        .wired     (e_wired),
        .rr_ptr    (rr_ptr),
        .victim_idx(victim_idx),
        .victim_ok (victim_ok),
        .use_rr    (use_rr)
    );

    sat_counter #(.W(CNT_W)) u_hits (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (lk_fire && hit),
        .count(hit_count)
    );

    sat_counter #(.W(CNT_W)) u_misses (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (lk_fire && !hit),
        .count(miss_count)
    );

    // response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_paddr_q <= '0;
            rsp_perm_q  <= '0;
        end else begin
            rsp_valid_q <= lk_fire;
            rsp_hit_q   <= lk_fire && hit;
            rsp_paddr_q <= (lk_fire && hit) ? {e_pfn[hit_idx], lk_off} : '0;
            rsp_perm_q  <= (lk_fire && hit) ? e_perm[hit_idx] : '0;
        end
    end

    // entry array, replacement pointer, overflow pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid    <= '0;
            e_wired    <= '0;
            e_global   <= '0;
            e_vpn      <= '0;
            e_asid     <= '0;
            e_pfn      <= '0;
            e_perm     <= '0;
            rr_ptr     <= '0;
            overflow_q <= 1'b0;
        end else begin
            overflow_q <= 1'b0;
            if (flush_valid) begin
                for (int i = 0; i < N; i++) begin
                    if (!e_wired[i] &&
                        (!flush_by_asid ||
                         (!e_global[i] && e_asid[i] == flush_asid))) begin
                        e_valid[i] <= 1'b0;
                    end
                end
            end
            if (fill_fire) begin
                if (victim_ok) begin
                    e_valid[victim_idx]  <= 1'b1;
                    e_wired[victim_idx]  <= fill_wired;
                    e_global[victim_idx] <= fill_global;
                    e_vpn[victim_idx]    <= fill_vpn;
                    e_asid[victim_idx]   <= fill_asid;
                    e_pfn[victim_idx]    <= fill_pfn;
                    e_perm[victim_idx]   <= fill_perm;
                    if (use_rr) begin
                        rr_ptr <= (int'(victim_idx) == N - 1) ? '0
                                                              : victim_idx + 1'b1;
                    end
                end else begin
                    overflow_q <= 1'b1;
                end
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_paddr = rsp_paddr_q;
    assign rsp_perm  = rsp_perm_q;
    assign overflow  = overflow_q;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int N     = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             fill_ready,
    input logic             flush_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             overflow,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [N-1:0]     hit_vec,
    input logic [N-1:0]     e_valid,
    input logic [N-1:0]     e_wired
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(hit_vec)); // R2

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid); // R1

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid); // R1

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!lk_ready && !flush_valid) || !lk_ready); // R4

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_ready && fill_ready)); // R4

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (!lk_ready && !fill_ready)); // R11

    AST_WIRED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wired & ~e_valid) == '0); // R7

    AST_WIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(e_wired) & ~e_wired) == '0)); // R7

    AST_OVF_ALL_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&e_wired)); // R8

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> !overflow); // R8

    AST_HIT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == CMAX) |=> (hit_count == CMAX)); // R12

    AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == CMAX) |=> (miss_count == CMAX)); // R12

endmodule

bind asid_tlb tlb_checker #(.N(ENTRIES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .fill_ready (fill_ready),
    .flush_valid(flush_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .overflow   (overflow),
    .hit_count  (hit_count),
    .miss_count (miss_count),
    .hit_vec    (hit_vec),
    .e_valid    (e_valid),
    .e_wired    (e_wired)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

    localparam int N      = 4;
    localparam int VPN_W  = 8;
    localparam int PFN_W  = 8;
    localparam int ASID_W = 4;
    localparam int OFF_W  = 4;
    localparam int PERM_W = 3;
    localparam int CNT_W  = 5;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [OFF_W-1:0] lk_off = '0;
    logic lk_ready, rsp_valid, rsp_hit, fill_ready, overflow;
    logic [PFN_W+OFF_W-1:0] rsp_paddr;
    logic [PERM_W-1:0] rsp_perm;
    logic fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic fill_global = 1'b0;
    logic fill_wired = 1'b0;
    logic flush_valid = 1'b0;
    logic flush_mode = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;
    logic [CNT_W-1:0] hit_count, miss_count;

    int total = 0;
    int bad = 0;
    bit armed = 0;

    always #5 clk = ~clk;

    asid_tlb #(
        .ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
        .OFF_W(OFF_W), .PERM_W(PERM_W), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_off(lk_off),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_global(fill_global),
        .fill_wired(fill_wired), .fill_ready(fill_ready),
        .flush_valid(flush_valid), .flush_mode(flush_mode), .flush_asid(flush_asid),
        .overflow(overflow), .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_valid[N], m_wired[N], m_glob[N], m_vpn[N], m_asid[N], m_pfn[N], m_perm[N];
    int m_rr, m_wait, m_rsp_valid, m_rsp_hit, m_paddr, m_perm_o, m_ovf, m_hits, m_misses;

    always @(posedge clk) begin : model
        bit lk_acc, fill_acc;
        int at, vic;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_valid[i] = 0; m_wired[i] = 0; m_glob[i] = 0;
                m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
            end
            m_rr = 0; m_wait = 0; m_rsp_valid = 0; m_rsp_hit = 0;
            m_paddr = 0; m_perm_o = 0; m_ovf = 0; m_hits = 0; m_misses = 0;
        end else begin
            lk_acc   = lk_valid && (m_wait == 0) && !flush_valid;
            fill_acc = fill_valid && (m_wait == 1) && !flush_valid;
            m_rsp_valid = lk_acc; m_rsp_hit = 0; m_paddr = 0; m_perm_o = 0; m_ovf = 0;
            if (lk_acc) begin
                at = -1;
                for (int i = 0; i < N; i++)
                    if (at < 0 && m_valid[i] == 1 && m_vpn[i] == int'(lk_vpn) &&
                        (m_glob[i] == 1 || m_asid[i] == int'(lk_asid))) at = i;
                if (at >= 0) begin
                    m_rsp_hit = 1;
                    m_paddr = m_pfn[at] * (1 << OFF_W) + int'(lk_off);
                    m_perm_o = m_perm[at];
                    if (m_hits < CMAX) m_hits++;
                end else begin
                    m_wait = 1;
                    if (m_misses < CMAX) m_misses++;
                end
            end
            if (flush_valid) begin
                for (int i = 0; i < N; i++)
                    if (m_wired[i] == 0 && (!flush_mode ||
                        (m_glob[i] == 0 && m_asid[i] == int'(flush_asid)))) m_valid[i] = 0;
            end
            if (fill_acc) begin
                vic = -1;
                for (int i = 0; i < N; i++) if (vic < 0 && m_valid[i] == 0) vic = i;
                if (vic < 0) begin
                    for (int k = 0; k < N; k++)
                        if (vic < 0 && m_wired[(m_rr + k) % N] == 0) vic = (m_rr + k) % N;
                    if (vic >= 0) m_rr = (vic + 1) % N;
                end
                if (vic >= 0) begin
                    m_valid[vic] = 1; m_wired[vic] = fill_wired; m_glob[vic] = fill_global;
                    m_vpn[vic] = fill_vpn; m_asid[vic] = fill_asid;
                    m_pfn[vic] = fill_pfn; m_perm[vic] = fill_perm;
                end else m_ovf = 1;
                m_wait = 0;
            end
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (armed && rst_n) begin
            chk("R1 rsp_valid", rsp_valid, m_rsp_valid);
            chk("R1 rsp_hit", rsp_hit, m_rsp_hit);
            chk("R1 rsp_paddr", int'(rsp_paddr), m_paddr);
            chk("R1 rsp_perm", int'(rsp_perm), m_perm_o);
            chk("R8 overflow", overflow, m_ovf);
            chk("R12 hit_count", int'(hit_count), m_hits);
            chk("R12 miss_count", int'(miss_count), m_misses);
            chk("R4 lk_ready", lk_ready, (m_wait == 0 && !flush_valid) ? 1 : 0);
            chk("R4 fill_ready", fill_ready, (m_wait == 1 && !flush_valid) ? 1 : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic look(input int vpn, input int asid, input int off,
                        input int exp_hit, input int exp_pfn, input string tag);
        @(posedge clk); #1;
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_off = OFF_W'(off);
        @(posedge clk); #1;
        lk_valid = 0;
        chk(tag, rsp_hit, exp_hit);
        if (exp_hit == 1) chk(tag, int'(rsp_paddr), exp_pfn * (1 << OFF_W) + off);
    endtask

    task automatic fill(input int vpn, input int asid, input int pfn, input int perm,
                        input bit glob, input bit wired);
        @(posedge clk); #1;
        fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
        fill_pfn = PFN_W'(pfn); fill_perm = PERM_W'(perm);
        fill_global = glob; fill_wired = wired;
        @(posedge clk); #1;
        fill_valid = 0; fill_global = 0; fill_wired = 0;
    endtask

    task automatic flush(input bit mode, input int asid);
        @(posedge clk); #1;
        flush_valid = 1; flush_mode = mode; flush_asid = ASID_W'(asid);
        @(posedge clk); #1;
        flush_valid = 0;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R13 reset state
        chk("R13 lk_ready", lk_ready, 1);
        chk("R13 rsp_valid", rsp_valid, 0);
        chk("R13 hit_count", int'(hit_count), 0);
        chk("R13 miss_count", int'(miss_count), 0);
        chk("R13 overflow", overflow, 0);
        rst_n = 1; armed = 1;

        // R4, R5, R1: miss, refill into slot 0, then hit
        look(8'h10, 1, 5, 0, 0, "R4 first miss");
        chk("R4 lk_ready low in refill", lk_ready, 0);
        chk("R4 fill_ready high in refill", fill_ready, 1);
        fill(8'h10, 1, 8'hA1, 3, 0, 0);
        look(8'h10, 1, 5, 1, 8'hA1, "R5 hit after fill");
        chk("R1 perm", int'(rsp_perm), 3);

        // R2: identifier mismatch misses
        look(8'h10, 2, 1, 0, 0, "R2 other asid misses");
        fill(8'h10, 2, 8'hB2, 1, 0, 0);
        look(8'h10, 2, 2, 1, 8'hB2, "R2 own asid hits");

        // R3: global entry
        look(8'h20, 1, 0, 0, 0, "R3 miss before global fill");
        fill(8'h20, 1, 8'hC3, 5, 1, 0);
        look(8'h20, 5, 7, 1, 8'hC3, "R3 global hits other asid");

        // pinned entry in slot 3
        look(8'h30, 1, 0, 0, 0, "R7 miss before pinned fill");
        fill(8'h30, 1, 8'hD4, 7, 0, 1);

        // R6: round robin once full
        look(8'h40, 1, 0, 0, 0, "R6 miss when full");
        fill(8'h40, 1, 8'hE5, 2, 0, 0);
        look(8'h10, 1, 3, 0, 0, "R6 slot0 was evicted");
        fill(8'h10, 1, 8'hA1, 3, 0, 0);
        look(8'h40, 1, 1, 1, 8'hE5, "R6 new entry hits");
        look(8'h10, 2, 0, 0, 0, "R6 slot1 was evicted");
        fill(8'h10, 2, 8'hB2, 1, 0, 0);
        look(8'h50, 1, 0, 0, 0, "R7 miss with pointer at pinned slot");
        fill(8'h50, 1, 8'hF6, 4, 0, 0);
        look(8'h30, 1, 9, 1, 8'hD4, "R7 pinned entry kept");
        look(8'h40, 1, 0, 0, 0, "R7 victim skipped to slot0");
        fill(8'h40, 1, 8'hE5, 2, 0, 0);

        // R10: flush by asid
        flush(1, 1);
        look(8'h10, 2, 4, 1, 8'hB2, "R10 other asid kept");
        look(8'h30, 1, 4, 1, 8'hD4, "R10 pinned kept");
        look(8'h50, 1, 0, 0, 0, "R10 flushed entry misses");
        fill(8'h50, 1, 8'hF6, 4, 0, 0);
        look(8'h60, 3, 0, 0, 0, "R10 miss before global");
        fill(8'h60, 3, 8'h77, 6, 1, 0);
        flush(1, 3);
        look(8'h60, 3, 2, 1, 8'h77, "R10 global kept");

        // R11 + R9: lookup in the same cycle as flush-all
        @(posedge clk); #1;
        lk_valid = 1; lk_vpn = 8'h60; lk_asid = 3;
        flush_valid = 1; flush_mode = 0;
        @(posedge clk); #1;
        lk_valid = 0; flush_valid = 0;
        chk("R11 no response during flush", rsp_valid, 0);
        look(8'h10, 2, 0, 0, 0, "R9 entry cleared by flush all");
        fill(8'h10, 2, 8'hB2, 1, 0, 0);
        look(8'h30, 1, 6, 1, 8'hD4, "R9 pinned survives flush all");

        // R8: pin everything, then overflow
        look(8'h70, 1, 0, 0, 0, "R8 miss");
        fill(8'h70, 1, 8'h17, 1, 0, 1);
        look(8'h80, 1, 0, 0, 0, "R8 miss");
        fill(8'h80, 1, 8'h18, 1, 0, 1);
        look(8'h90, 1, 0, 0, 0, "R8 miss");
        fill(8'h90, 1, 8'h19, 1, 0, 1);
        fill(8'hA0, 1, 8'h1A, 1, 0, 1);
        look(8'hA0, 1, 0, 0, 0, "R4 idle fill ignored");
        fill(8'hA0, 1, 8'h1A, 1, 0, 1);
        chk("R8 overflow pulse", overflow, 1);
        chk("R8 back to lookup", lk_ready, 1);
        look(8'hA0, 1, 0, 0, 0, "R8 dropped fill not stored");
        fill(8'hA0, 1, 8'h1A, 1, 0, 0);
        @(posedge clk); #1;
        chk("R8 pulse is one cycle", overflow, 0);

        // R12: saturation
        for (int i = 0; i < 40; i++) look(8'h30, 1, i % 16, 1, 8'hD4, "R12 repeated hit");
        chk("R12 hit counter saturates", int'(hit_count), CMAX);

        repeat (2) @(posedge clk);
        #1;
        report();
    end

endmodule